// File: doc/BRIEF.md
# Pipelined Sample Store with Board Energy Sum

This block sits behind a sixteen-channel digitizer that delivers one 12-bit unsigned sample per channel on every clock. Each cycle it writes the full set of channel samples into a circular store that holds more than the trigger decision time, so data is still present when an accept arrives. Each cycle it also removes a per-channel baseline from every sample, with negative results floored at zero. It adds the sixteen corrected values in a registered adder tree and presents the total as the board energy sum for the next level of triggering.

When a trigger pulse arrives, the block records where the readout must start, which is the current write position minus a look-back distance. It also records how many samples to return. A single readout engine then returns that window as consecutive words, with all channels in each word. Triggers that arrive during a readout wait in a four-entry queue. The look-back distance and window length are sampled on the trigger cycle, so each queued request keeps its own settings.

Top module: `fadc_latency_sum`

## Requirements
- R1: Channel c occupies bits [12c+11:12c] of both the sample bus and the baseline bus. The sample set presented at clock edge k appears on sum_o from edge k+3 until edge k+4, which is a latency of four register stages. sum_o equals the sum over all channels of max(sample − baseline, 0).
- R2: A channel whose baseline is equal to or greater than its sample adds exactly 0 to the sum. Other channels are not affected.
- R3: While rst_ni is low, sum_o is 0, and rd_valid_o, rd_last_o and busy_o are 0.
- R4: The edge after reset release is edge 0. A trigger accepted at edge T with look-back L returns the sample sets presented at edges T−L, T−L+1, and so on, in that order. Each word uses the same channel layout as the sample bus.
- R5: A window of length W returns exactly W words. rd_last_o is high with the last word only.
- R6: Within one window, rd_valid_o stays high on consecutive cycles until the last word.
- R7: Triggers accepted during a readout are queued and served in arrival order. Each uses the look-back and window length present on its own trigger cycle.
- R8: busy_o is high while four requests are pending. A trigger at an edge where busy_o was high is dropped and never produces a readout. A trigger while the block is idle and not busy is always accepted.
- R9: A look-back above 2000 is treated as 2000.
- R10: A window length of 0 produces no readout words.
- R11: The store holds 2048 positions and its addresses wrap modulo 2048. A window that crosses the wrap point returns its samples in the same order as one that does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 192 | Current sample of every channel, channel c at bits 12c+11:12c |
| pedestal_i | input | 192 | Baseline of every channel, same layout, held static |
| lookback_i | input | 11 | Look-back distance in samples, sampled on the trigger |
| window_i | input | 11 | Readout window length in samples, sampled on the trigger |
| trigger_i | input | 1 | Readout request, one per cycle it is high |
| sum_o | output | 16 | Baseline-corrected sum of all channels |
| rd_valid_o | output | 1 | Readout word valid |
| rd_last_o | output | 1 | Final word of the current window |
| rd_data_o | output | 192 | Readout word, all channels |
| busy_o | output | 1 | Request queue full; new triggers are dropped |

## Verification
The bench keeps every sample set it has driven, indexed by edge. It checks sum_o on every cycle against the sample set from three edges before, so a design with one register too many or too few in the tree fails at once. Baselines rise across the channels, so many channels are floored at zero, and a fixed test with one value on all channels exposes a missing floor or sign extension. The triggered reads cover a window that crosses address 2047 to 0, a look-back above 2000, a window of length 1 and a window of length 0. A wrong start address, an off-by-one in the window count, or a missing clamp shows up as a mismatched or extra word. A burst of six triggers fills the queue. A design that serves requests out of order, accepts a trigger while full, or raises busy at the wrong count produces a readout stream that does not match the expected one.

// File: rtl/fadc_pkg.sv
package fadc_pkg;
  localparam int unsigned N_CH_DEF         = 16;
  localparam int unsigned SAMPLE_W_DEF     = 12;
  localparam int unsigned DEPTH_DEF        = 2048;
  localparam int unsigned MAX_LOOKBACK_DEF = 2000;
  localparam int unsigned FIFO_DEPTH_DEF   = 4;
endpackage

// File: rtl/fadc_pedsum.sv
module fadc_pedsum #(
  parameter int unsigned N_CH     = fadc_pkg::N_CH_DEF,
  parameter int unsigned SAMPLE_W = fadc_pkg::SAMPLE_W_DEF
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [N_CH*SAMPLE_W-1:0]              sample_i,
  input  logic [N_CH*SAMPLE_W-1:0]              pedestal_i,
  output logic [SAMPLE_W+$clog2(N_CH)-1:0]      sum_o
);
  localparam int unsigned SUM_W = SAMPLE_W + $clog2(N_CH);

  logic [SUM_W-1:0] diff [N_CH];
  logic [SUM_W-1:0] node_q [1:N_CH-1];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [SAMPLE_W:0] d;
    assign d = {1'b0, sample_i[c*SAMPLE_W +: SAMPLE_W]}
             - {1'b0, pedestal_i[c*SAMPLE_W +: SAMPLE_W]};
    // borrow out means sample below baseline: floor at zero
    assign diff[c] = d[SAMPLE_W] ? '0 : SUM_W'(d[SAMPLE_W-1:0]);
  end

  // heap-indexed tree: node i sums children 2i and 2i+1, leaves are diff[]
  for (genvar i = 1; i < N_CH; i++) begin : g_node
    logic [SUM_W-1:0] lhs, rhs;
    if (2*i >= N_CH) begin : g_leaf
      assign lhs = diff[2*i-N_CH];
      assign rhs = diff[2*i+1-N_CH];
    end else begin : g_inner
      assign lhs = node_q[2*i];
      assign rhs = node_q[2*i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) node_q[i] <= '0;
      else         node_q[i] <= lhs + rhs;
    end
  end

  assign sum_o = node_q[1];
endmodule

// File: rtl/fadc_req_fifo.sv
module fadc_req_fifo #(
  parameter int unsigned DATA_W = 22,
  parameter int unsigned DEPTH  = fadc_pkg::FIFO_DEPTH_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] store_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = store_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int k = 0; k < DEPTH; k++) store_q[k] <= '0;
    end else begin
      if (do_push) begin
        store_q[wr_q] <= data_i;
        wr_q <= (wr_q == PTR_W'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      end
      if (do_pop) rd_q <= (rd_q == PTR_W'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/fadc_ring.sv
module fadc_ring #(
  parameter int unsigned N_CH         = fadc_pkg::N_CH_DEF,
  parameter int unsigned SAMPLE_W     = fadc_pkg::SAMPLE_W_DEF,
  parameter int unsigned DEPTH        = fadc_pkg::DEPTH_DEF,
  parameter int unsigned MAX_LOOKBACK = fadc_pkg::MAX_LOOKBACK_DEF,
  parameter int unsigned FIFO_DEPTH   = fadc_pkg::FIFO_DEPTH_DEF
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CH*SAMPLE_W-1:0]   sample_i,
  input  logic [$clog2(DEPTH)-1:0]   lookback_i,
  input  logic [$clog2(DEPTH)-1:0]   window_i,
  input  logic                       trigger_i,
  output logic                       rd_valid_o,
  output logic                       rd_last_o,
  output logic [N_CH*SAMPLE_W-1:0]   rd_data_o,
  output logic                       busy_o
);
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned WORD_W = N_CH * SAMPLE_W;
  localparam int unsigned REQ_W  = 2 * ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wp_q, rd_addr_q, remain_q, lb_eff;
  logic              active_q, valid_q, last_q;
  logic [WORD_W-1:0] data_q;
  logic [REQ_W-1:0]  req_in, req_out;
  logic              q_empty, q_full, pop;
  logic [ADDR_W-1:0] pop_start, pop_len;

  assign lb_eff = (lookback_i > ADDR_W'(MAX_LOOKBACK)) ? ADDR_W'(MAX_LOOKBACK) : lookback_i;
  assign req_in = {wp_q - lb_eff, window_i};
  assign pop    = !active_q && !q_empty;
  assign {pop_start, pop_len} = req_out;

  fadc_req_fifo #(.DATA_W(REQ_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (trigger_i),
    .data_i  (req_in),
    .pop_i   (pop),
    .data_o  (req_out),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  always_ff @(posedge clk_i) begin
    mem[wp_q] <= sample_i;
    data_q    <= mem[rd_addr_q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q      <= '0;
      rd_addr_q <= '0;
      remain_q  <= '0;
      active_q  <= 1'b0;
      valid_q   <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      wp_q    <= wp_q + 1'b1;
      valid_q <= active_q;
      last_q  <= active_q && (remain_q == ADDR_W'(1));
      if (active_q) begin
        rd_addr_q <= rd_addr_q + 1'b1;
        remain_q  <= remain_q - 1'b1;
        if (remain_q == ADDR_W'(1)) active_q <= 1'b0;
      end else if (pop && (pop_len != '0)) begin
        active_q  <= 1'b1;
        rd_addr_q <= pop_start;
        remain_q  <= pop_len;
      end
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_last_o  = last_q;
  assign rd_data_o  = data_q;
  assign busy_o     = q_full;
endmodule

// File: rtl/fadc_latency_sum.sv
module fadc_latency_sum #(
  parameter int unsigned N_CH         = fadc_pkg::N_CH_DEF,
  parameter int unsigned SAMPLE_W     = fadc_pkg::SAMPLE_W_DEF,
  parameter int unsigned DEPTH        = fadc_pkg::DEPTH_DEF,
  parameter int unsigned MAX_LOOKBACK = fadc_pkg::MAX_LOOKBACK_DEF,
  parameter int unsigned FIFO_DEPTH   = fadc_pkg::FIFO_DEPTH_DEF
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [N_CH*SAMPLE_W-1:0]           sample_i,
  input  logic [N_CH*SAMPLE_W-1:0]           pedestal_i,
  input  logic [$clog2(DEPTH)-1:0]           lookback_i,
  input  logic [$clog2(DEPTH)-1:0]           window_i,
  input  logic                               trigger_i,
  output logic [SAMPLE_W+$clog2(N_CH)-1:0]   sum_o,
  output logic                               rd_valid_o,
  output logic                               rd_last_o,
  output logic [N_CH*SAMPLE_W-1:0]           rd_data_o,
  output logic                               busy_o
);
  fadc_pedsum #(.N_CH(N_CH), .SAMPLE_W(SAMPLE_W)) u_sum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample_i),
    .pedestal_i (pedestal_i),
    .sum_o      (sum_o)
  );

  fadc_ring #(
    .N_CH(N_CH), .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH),
    .MAX_LOOKBACK(MAX_LOOKBACK), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample_i),
    .lookback_i (lookback_i),
    .window_i   (window_i),
    .trigger_i  (trigger_i),
    .rd_valid_o (rd_valid_o),
    .rd_last_o  (rd_last_o),
    .rd_data_o  (rd_data_o),
    .busy_o     (busy_o)
  );
endmodule

// File: rtl/fadc_latency_sum_chk.sv
module fadc_latency_sum_chk #(
  parameter int unsigned N_CH     = fadc_pkg::N_CH_DEF,
  parameter int unsigned SAMPLE_W = fadc_pkg::SAMPLE_W_DEF
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               trigger_i,
  input logic                               busy_o,
  input logic                               rd_valid_o,
  input logic                               rd_last_o,
  input logic [SAMPLE_W+$clog2(N_CH)-1:0]   sum_o
);
  localparam int unsigned SUM_W = SAMPLE_W + $clog2(N_CH);
  localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'(N_CH * ((1 << SAMPLE_W) - 1));

  p_last_in_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_valid_o);

  p_window_contig_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_last_o |=> rd_valid_o);

  p_sum_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o <= SUM_MAX);

  p_busy_after_trig_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(trigger_i));

  p_last_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |=> !rd_last_o);
endmodule

bind fadc_latency_sum fadc_latency_sum_chk #(.N_CH(N_CH), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trigger_i  (trigger_i),
  .busy_o     (busy_o),
  .rd_valid_o (rd_valid_o),
  .rd_last_o  (rd_last_o),
  .sum_o      (sum_o)
);

// File: tb/tb_fadc_latency_sum.sv
`timescale 1ns/1ps
module tb_fadc_latency_sum;
  localparam int NC = 16, SW = 12, AW = 11, SUMW = 16, WW = NC*SW, MAXLB = 2000;
  localparam int NVEC = 7;
  // {look-back, window, requirement number}
  localparam logic [AW+AW+3:0] VEC [NVEC] = '{
    {11'd6,    11'd5,  4'd11},
    {11'd100,  11'd16, 4'd4},
    {11'd2040, 11'd8,  4'd9},
    {11'd2000, 11'd1,  4'd5},
    {11'd50,   11'd0,  4'd10},
    {11'd300,  11'd64, 4'd4},
    {11'd1,    11'd1,  4'd5}
  };

  logic clk = 1'b0, rst_ni = 1'b1;
  logic [WW-1:0] sample_i, pedestal_i;
  logic [AW-1:0] lookback_i, window_i;
  logic trigger_i;
  logic [SUMW-1:0] sum_o;
  logic rd_valid_o, rd_last_o, busy_o;
  logic [WW-1:0] rd_data_o;

  fadc_latency_sum dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .pedestal_i(pedestal_i),
    .lookback_i(lookback_i), .window_i(window_i), .trigger_i(trigger_i),
    .sum_o(sum_o), .rd_valid_o(rd_valid_o), .rd_last_o(rd_last_o),
    .rd_data_o(rd_data_o), .busy_o(busy_o)
  );

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, e = 0, cyc = 0, acc_cnt = 0;
  logic [WW-1:0] hist [0:8191];
  int    exp_idx[$];
  bit    exp_last[$];
  string exp_tag[$];
  bit ovr_en = 0, saw_busy = 0, rd_seen = 0;
  logic [SW-1:0] ovr_val = '0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung act=%0d exp<=100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [SW-1:0] gen(int k, int c);
    return SW'((k*37 + c*511 + (k>>2)*(c+3)) & 4095);
  endfunction

  function automatic logic [SW-1:0] ped(int c);
    return SW'(c*200);
  endfunction

  function automatic int exp_sum(logic [WW-1:0] w);
    int acc = 0;
    for (int c = 0; c < NC; c++) begin
      int s = int'(w[c*SW +: SW]);
      int p = int'(ped(c));
      if (s > p) acc += s - p;
    end
    return acc;
  endfunction

  task automatic check(bit ok, string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // drive one cycle at a negedge, advance past one edge, check at the next negedge
  task automatic step(bit trig, int lb, int win, string tag);
    logic [WW-1:0] w;
    int m;
    for (int c = 0; c < NC; c++) w[c*SW +: SW] = ovr_en ? ovr_val : gen(e, c);
    sample_i   = w;
    hist[e]    = w;
    trigger_i  = trig;
    lookback_i = AW'(lb);
    window_i   = AW'(win);
    if (busy_o) saw_busy = 1;
    if (trig && !busy_o) begin
      int lc = (lb > MAXLB) ? MAXLB : lb;
      acc_cnt++;
      for (int i = 0; i < win; i++) begin
        exp_idx.push_back(e - lc + i);
        exp_last.push_back(i == win - 1);
        exp_tag.push_back(tag);
      end
    end
    @(posedge clk);
    @(negedge clk);
    m = e;
    e++;
    trigger_i = 1'b0;
    if (m >= 3)
      check(int'(sum_o) == exp_sum(hist[m-3]),
            $sformatf("R1 sum after edge %0d act=%0d exp=%0d", m, sum_o, exp_sum(hist[m-3])));
    if (rd_valid_o) begin
      rd_seen = 1;
      if (exp_idx.size() == 0) begin
        check(0, $sformatf("R8 unexpected readout word act=%0h exp=none", rd_data_o));
      end else begin
        int idx = exp_idx.pop_front();
        bit lst = exp_last.pop_front();
        string t = exp_tag.pop_front();
        check(rd_data_o == hist[idx],
              $sformatf("%s data of edge %0d act=%0h exp=%0h", t, idx, rd_data_o, hist[idx]));
        check(rd_last_o == lst,
              $sformatf("R5 last flag (%s) act=%0b exp=%0b", t, rd_last_o, lst));
      end
    end
  endtask

  task automatic drain(string tag);
    int n = 0;
    while ((exp_idx.size() != 0 || rd_valid_o) && n < 2000) begin
      step(0, 0, 0, tag);
      n++;
    end
    repeat (4) step(0, 0, 0, tag);
    check(exp_idx.size() == 0,
          $sformatf("R5 words missing after %s act=%0d exp=0", tag, exp_idx.size()));
  endtask

  initial begin
    int e0;
    for (int c = 0; c < NC; c++) pedestal_i[c*SW +: SW] = ped(c);
    sample_i = '0; trigger_i = 0; lookback_i = '0; window_i = '0;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(sum_o == '0,   $sformatf("R3 sum in reset act=%0d exp=0", sum_o));
    check(!rd_valid_o,   $sformatf("R3 rd_valid in reset act=%0b exp=0", rd_valid_o));
    check(!rd_last_o,    $sformatf("R3 rd_last in reset act=%0b exp=0", rd_last_o));
    check(!busy_o,       $sformatf("R3 busy in reset act=%0b exp=0", busy_o));
    rst_ni = 1'b1;

    repeat (20) step(0, 0, 0, "R1");

    // R2: common value below most baselines
    ovr_en = 1; ovr_val = 12'd1500;
    e0 = e;
    repeat (4) step(0, 0, 0, "R2");
    check(sum_o == 16'd6400, $sformatf("R2 floored sum of edge %0d act=%0d exp=6400", e0, sum_o));
    repeat (4) step(0, 0, 0, "R2");
    ovr_en = 0;

    while (e < 2050) step(0, 0, 0, "R1");

    for (int v = 0; v < NVEC; v++) begin
      int lb  = int'(VEC[v][AW+AW+3 -: AW]);
      int win = int'(VEC[v][AW+3 -: AW]);
      int rq  = int'(VEC[v][3:0]);
      string tag;
      case (rq)
        11:      tag = "R11";
        9:       tag = "R9";
        10:      tag = "R10";
        5:       tag = "R5";
        default: tag = "R4";
      endcase
      rd_seen = 0;
      step(1, lb, win, tag);
      drain(tag);
      if (win == 0)
        check(!rd_seen, $sformatf("R10 zero window gave words act=%0b exp=0", rd_seen));
    end

    // R7 / R8: burst of six triggers, one per cycle
    saw_busy = 0;
    acc_cnt = 0;
    for (int i = 0; i < 6; i++) step(1, 200 + 7*i, 30, "R7");
    check(saw_busy, $sformatf("R8 busy during burst act=%0b exp=1", saw_busy));
    check(acc_cnt == 5, $sformatf("R8 accepted triggers act=%0d exp=5", acc_cnt));
    drain("R7");
    check(!busy_o, $sformatf("R8 busy after drain act=%0b exp=0", busy_o));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule